// File: doc/BRIEF.md
# Banked Register File Access Unit

This unit is the data-memory addressing front end of a small 8-bit accumulator-style controller core. Each accepted operation carries a 7-bit direct file offset, a destination bit, an operation kind and the result that the external ALU computed. The unit resolves the offset to an effective file address. Direct offsets are prefixed with the bank bit held in STATUS. Offset 0 is not storage: it stands for the location that the pointer register names. The unit then steers the result either into the working register (W) or back into the file.

Operand data flows out combinationally. For the offset and state presented this cycle, `rd_data` shows the addressed byte so that the ALU can work on it in the same cycle. The operation stream is a valid/ready interface. `req_ready` is low while reset is held and high in every cycle after it. An operation is taken on each rising edge where `req_valid` and `req_ready` are both high. Back-pressure never occurs outside reset, so a producer may hold `req_valid` high continuously. Two state registers live inside the file itself: STATUS at offset 0x03, whose bit 5 selects the bank, and the pointer at offset 0x04.

Top module: `bank_file_unit`

## Requirements
- R1: While reset is held, `req_ready` is 0. After reset `req_ready` is 1 from the first clock onward. W, STATUS, the pointer and every file byte come out of reset as 0x00, so bank 0 is selected.
- R2: A direct offset (not 0) addresses effective location {STATUS bit 5, offset}. `rd_data` shows that byte in the same cycle, with no clock delay.
- R3: The bank bit keeps its value across every operation that does not write offset 0x03. A write there takes effect from the next operation.
- R4: Offsets 0x02, 0x03, 0x04, 0x0A and 0x0B are one shared storage seen from both banks. Every other offset from 0x01 to 0x7F is separate storage in each bank, so bank-1 registers such as 0x81, 0x85, 0x86, 0x88 and 0x89 cannot be reached while the bank bit is 0.
- R5: Offset 0 reads and writes the location whose 8-bit address the pointer holds, with pointer bit 7 as the bank, whatever the STATUS bank bit. Stepping the pointer walks consecutive locations, for example 0x20 to 0x2F.
- R6: When the low 7 pointer bits are 0, offset 0 reads as 0x00 and a write through it changes nothing.
- R7: Kind 1 (byte operation) with destination 0 loads W with the ALU result and leaves the file unchanged. With destination 1 it writes the result to the file and leaves W unchanged.
- R8: The destination bit is ignored by the other kinds. Kind 2 clears the file byte, kind 3 clears W, kind 4 copies W to the file byte, and kind 0 and kinds 5 to 7 change nothing.
- R9: An operation resolves its address from the pointer and bank values held before it. A write through offset 0 to the pointer's own location therefore lands in the pointer, and the new value steers the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation present |
| req_ready | output | 1 | Operation accepted on this edge when valid |
| req_kind | input | 3 | Operation kind (0 none, 1 byte, 2 clear file, 3 clear W, 4 copy W to file) |
| req_addr | input | 7 | Direct file offset, 0 meaning indirect |
| req_dest | input | 1 | Destination for kind 1: 0 = W, 1 = file |
| alu_result | input | 8 | Result from the external ALU |
| rd_data | output | 8 | Operand byte at the resolved address |
| w_out | output | 8 | Working register |

## Verification
The checker watches, on every cycle, the rules that touch W: destination steering, clear-W and copy-W leaving W stable. It also checks that the bank bit holds whenever STATUS is not written, that a null pointer reads as zero, and that ready follows reset. Storage separation between the banks, mirroring of the shared offsets, the pointer walk through a block and the effect of pointer self-writes on later accesses only show up across sequences of operations. The bench's reference model shows these, together with its directed readbacks.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_BYTE  = 3'd1,
    K_CLRF  = 3'd2,
    K_CLRW  = 3'd3,
    K_MOVWF = 3'd4
  } bfu_kind_e;

  localparam int OFS_INDIRECT = 0;
  localparam int OFS_STATUS   = 3;
  localparam int OFS_POINTER  = 4;

  // Offsets whose storage is shared by both banks.
  function automatic bit is_mirrored(int ofs);
    return (ofs == 2) || (ofs == OFS_STATUS) || (ofs == OFS_POINTER) ||
           (ofs == 10) || (ofs == 11);
  endfunction

endpackage

// File: rtl/bfu_addr.sv
module bfu_addr #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic              bank,
  input  logic [ADDR_W:0]   ptr,
  output logic [ADDR_W:0]   phys,
  output logic              is_null
);
  import bfu_pkg::*;

  logic              indirect;
  logic [ADDR_W:0]   eff;
  logic [ADDR_W-1:0] eff_ofs;

  always_comb begin
    indirect = (dir_addr == ADDR_W'(OFS_INDIRECT));
    eff      = indirect ? ptr : {bank, dir_addr};
    eff_ofs  = eff[ADDR_W-1:0];
    is_null  = indirect && (ptr[ADDR_W-1:0] == '0);
    if (is_mirrored(int'(eff_ofs)))
      phys = {1'b0, eff_ofs};
    else
      phys = eff;
  end
endmodule

// File: rtl/bfu_steer.sv
module bfu_steer #(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        kind_i,
  input  logic              dest_i,
  input  logic [DATA_W-1:0] alu_i,
  input  logic [DATA_W-1:0] w_i,
  output logic              file_we,
  output logic [DATA_W-1:0] file_wd,
  output logic              w_we,
  output logic [DATA_W-1:0] w_wd
);
  import bfu_pkg::*;

  always_comb begin
    file_we = 1'b0;
    file_wd = '0;
    w_we    = 1'b0;
    w_wd    = '0;
    case (kind_i)
      K_BYTE: begin
        if (dest_i) begin
          file_we = 1'b1;
          file_wd = alu_i;
        end else begin
          w_we = 1'b1;
          w_wd = alu_i;
        end
      end
      K_CLRF:  file_we = 1'b1;
      K_CLRW:  w_we    = 1'b1;
      K_MOVWF: begin
        file_we = 1'b1;
        file_wd = w_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bfu_store.sv
module bfu_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W:0]   addr,
  input  logic [DATA_W-1:0] wd,
  input  logic              rd_null,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] ptr_o
);
  import bfu_pkg::*;

  localparam int DEPTH = 1 << (ADDR_W + 1);
  localparam int HALF  = DEPTH / 2;

  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam int OFS = i % HALF;
    localparam bit HOLE = (OFS == OFS_INDIRECT) || ((i >= HALF) && is_mirrored(OFS));
    if (HOLE) begin : g_hole
      assign cells[i] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (we && (addr == (ADDR_W+1)'(i)))
          q <= wd;
      end
      assign cells[i] = q;
    end
  end

  assign rdata    = rd_null ? '0 : cells[addr];
  assign status_o = cells[OFS_STATUS];
  assign ptr_o    = cells[OFS_POINTER];
endmodule

// File: rtl/bank_file_unit.sv
module bank_file_unit #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 7,
  parameter int RP0_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_dest,
  input  logic [DATA_W-1:0] alu_result,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] w_out
);
  localparam int AW1 = ADDR_W + 1;

  logic              ready_q;
  logic              fire;
  logic [DATA_W-1:0] w_q;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] ptr_q;
  logic [AW1-1:0]    phys_addr;
  logic              is_null;
  logic              file_we, w_we;
  logic [DATA_W-1:0] file_wd, w_wd;
  logic              store_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign req_ready = ready_q;
  assign fire      = req_valid && ready_q;

  bfu_addr #(.ADDR_W(ADDR_W)) u_addr (
    .dir_addr (req_addr),
    .bank     (status_q[RP0_BIT]),
    .ptr      (ptr_q[AW1-1:0]),
    .phys     (phys_addr),
    .is_null  (is_null)
  );

  bfu_steer #(.DATA_W(DATA_W)) u_steer (
    .kind_i  (req_kind),
    .dest_i  (req_dest),
    .alu_i   (alu_result),
    .w_i     (w_q),
    .file_we (file_we),
    .file_wd (file_wd),
    .w_we    (w_we),
    .w_wd    (w_wd)
  );

  assign store_we = fire && file_we && !is_null;

  bfu_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (store_we),
    .addr     (phys_addr),
    .wd       (file_wd),
    .rd_null  (is_null),
    .rdata    (rd_data),
    .status_o (status_q),
    .ptr_o    (ptr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              w_q <= '0;
    else if (fire && w_we)   w_q <= w_wd;
  end

  assign w_out = w_q;
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fire,
  input logic              req_ready,
  input logic [2:0]        kind,
  input logic              dest,
  input logic [DATA_W-1:0] alu,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] w_out,
  input logic              rp0,
  input logic              ptr_null,
  input logic              status_wr
);
  // R1: ready follows reset release
  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> req_ready);

  // R3: bank bit holds without a STATUS write
  a_r3_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !status_wr |=> $stable(rp0));

  // R6: null pointer reads as zero through offset 0
  a_r6_null_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0 && ptr_null) |-> rd_data == '0);

  // R7: destination 0 loads W with the result
  a_r7_dest_w_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == 3'd1 && !dest) |=> w_out == $past(alu));

  // R7: destination 1 leaves W alone
  a_r7_dest_file_keeps_w: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == 3'd1 && dest) |=> $stable(w_out));

  // R8: clear-W empties W
  a_r8_clrw_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == 3'd3) |=> w_out == '0);

  // R8: copy-W and clear-file leave W alone
  a_r8_file_kinds_keep_w: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (kind == 3'd4 || kind == 3'd2)) |=> $stable(w_out));
endmodule

bind bank_file_unit bfu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fire      (fire),
  .req_ready (req_ready),
  .kind      (req_kind),
  .dest      (req_dest),
  .alu       (alu_result),
  .addr      (req_addr),
  .rd_data   (rd_data),
  .w_out     (w_out),
  .rp0       (status_q[RP0_BIT]),
  .ptr_null  (ptr_q[ADDR_W-1:0] == '0),
  .status_wr (store_we && (phys_addr == (ADDR_W+1)'(3)))
);

// File: tb/sim_bank_file_unit.sv
module sim_bank_file_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_kind = '0;
  logic [6:0] req_addr = '0;
  logic       req_dest = 1'b0;
  logic [7:0] alu_result = '0;
  logic [7:0] rd_data;
  logic [7:0] w_out;

  always #4 clk = ~clk;

  bank_file_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_dest(req_dest),
    .alu_result(alu_result), .rd_data(rd_data), .w_out(w_out)
  );

  int m_mem [256];
  int m_w = 0;
  int n_chk = 0;
  int n_fail = 0;
  int last_rd = 0;
  bit live = 0;

  function automatic int m_phys(int e);
    int o = e & 127;
    if (o == 2 || o == 3 || o == 4 || o == 10 || o == 11) return o;
    return e & 255;
  endfunction

  function automatic int m_tgt(int a);
    int e;
    if (a == 0) begin
      e = m_mem[4];
      if ((e & 127) == 0) return -1;
      return m_phys(e);
    end
    e = (((m_mem[3] >> 5) & 1) * 128) + a;
    return m_phys(e);
  endfunction

  function automatic int m_rd(int a);
    int t = m_tgt(a);
    return (t < 0) ? 0 : m_mem[t];
  endfunction

  task automatic chk(int act, int exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (live) chk(int'(w_out), m_w, "R7 W vs model");

  task automatic op(int k, int a, bit d, int alu, string tag);
    int t;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'(k); req_addr = 7'(a);
    req_dest = d; alu_result = 8'(alu);
    #1;
    last_rd = int'(rd_data);
    chk(last_rd, m_rd(a), tag);
    t = m_tgt(a);
    @(posedge clk);
    case (k)
      1: if (d) begin if (t >= 0) m_mem[t] = alu & 255; end
         else m_w = alu & 255;
      2: if (t >= 0) m_mem[t] = 0;
      3: m_w = 0;
      4: if (t >= 0) m_mem[t] = m_w;
      default: ;
    endcase
  endtask

  task automatic peek(int a, int exp, string tag);
    op(0, a, 1'b1, 8'hFF, tag);
    chk(last_rd, exp, tag);
  endtask

  task automatic w_is(int exp, string tag);
    @(negedge clk);
    chk(int'(w_out), exp, tag);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    foreach (m_mem[i]) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    chk(int'(req_ready), 0, "R1 ready low in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(req_ready), 1, "R1 ready after reset");
    chk(int'(w_out), 0, "R1 W reset");
    live = 1;
    peek(3, 0, "R1 status reset");
    peek(4, 0, "R1 pointer reset");
    peek(8'h20, 0, "R1 gpr reset");

    // R7 destination steering
    op(1, 8'h20, 1, 8'h5A, "R7 write file");
    peek(8'h20, 8'h5A, "R7 file holds result");
    op(1, 8'h20, 0, 8'h11, "R7 dest W");
    peek(8'h20, 8'h5A, "R7 file unchanged by dest W");
    w_is(8'h11, "R7 W loaded");

    // R8 fixed-target kinds
    op(2, 8'h20, 0, 8'h99, "R8 clear file");
    peek(8'h20, 0, "R8 clear file ignores dest");
    w_is(8'h11, "R8 clear file keeps W");
    op(1, 8'h21, 1, 8'h33, "R8 setup");
    op(3, 8'h21, 1, 8'h44, "R8 clear W");
    w_is(0, "R8 W cleared");
    peek(8'h21, 8'h33, "R8 clear W keeps file");
    op(1, 8'h30, 0, 8'h6C, "R8 load W");
    op(4, 8'h22, 0, 8'h00, "R8 copy W");
    peek(8'h22, 8'h6C, "R8 copy W to file");
    op(0, 8'h21, 1, 8'hFF, "R8 none");
    peek(8'h21, 8'h33, "R8 none changes nothing");
    op(7, 8'h21, 1, 8'hEE, "R8 undefined kind");
    peek(8'h21, 8'h33, "R8 undefined kind changes nothing");

    // R2 R3 R4 banking and mirroring
    op(1, 8'h05, 1, 8'h12, "R4 bank0 port");
    op(1, 8'h0A, 1, 8'h3C, "R4 mirrored write");
    op(1, 3, 1, 8'h20, "R3 select bank1");
    peek(8'h05, 0, "R4 bank1 own register");
    op(1, 8'h05, 1, 8'h55, "R4 bank1 write");
    peek(8'h0A, 8'h3C, "R4 mirror seen in bank1");
    peek(8'h20, 0, "R2 bank1 gpr distinct");
    peek(3, 8'h20, "R3 status seen in bank1");
    op(1, 8'h0B, 1, 8'h7E, "R4 mirror from bank1");
    peek(8'h05, 8'h55, "R3 bank held");
    op(1, 3, 1, 0, "R3 select bank0");
    peek(8'h05, 8'h12, "R4 bank1-only unreachable");
    peek(8'h0B, 8'h7E, "R4 mirror seen in bank0");

    // R5 R9 indirect access
    op(1, 4, 1, 8'h22, "R5 set pointer");
    peek(0, 8'h6C, "R5 indirect read");
    op(1, 4, 1, 8'h04, "R9 point at pointer");
    op(1, 0, 1, 8'h21, "R9 indirect write to pointer");
    peek(4, 8'h21, "R9 pointer rewritten");
    peek(0, 8'h33, "R9 next access uses new pointer");
    op(1, 4, 1, 8'h20, "R5 block start");
    for (int i = 0; i < 16; i++) begin
      op(1, 0, 1, 8'hAA, "R5 block fill");
      op(1, 4, 1, 8'h21 + i, "R5 pointer step");
    end
    for (int i = 0; i < 16; i++) peek(8'h20 + i, 8'hAA, "R5 block readback");
    peek(8'h30, 0, "R5 block end untouched");
    op(1, 4, 1, 8'hA0, "R5 pointer into bank1");
    op(1, 0, 1, 8'h5D, "R5 indirect bank1 write");
    peek(8'h20, 8'hAA, "R5 bank0 untouched");
    op(1, 3, 1, 8'h20, "R5 select bank1");
    peek(8'h20, 8'h5D, "R5 bank1 target written");
    op(1, 3, 1, 0, "R5 select bank0");

    // R6 null pointer
    op(1, 4, 1, 0, "R6 null pointer");
    op(1, 0, 1, 8'h77, "R6 null write");
    peek(0, 0, "R6 null read");
    peek(4, 0, "R6 pointer unchanged");
    op(1, 4, 1, 8'h80, "R6 bank1 null pointer");
    op(1, 0, 1, 8'h66, "R6 bank1 null write");
    peek(0, 0, "R6 bank1 null read");
    peek(3, 0, "R6 status unchanged");

    @(negedge clk);
    req_valid = 1'b0;
    live = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule